// File: doc/BRIEF.md
# Programmable Skew Clock Phase Generator

This block derives four pairs of output clocks from one fast master clock. A base counter runs modulo N master cycles, and N is the nominal output period. A three-level frequency-select input picks N from 44, 26 or 16. One time unit equals one master clock period, so the time unit is 1/N of the nominal period. Each output pair has a two-digit three-level control code. The code either shifts the pair by a signed whole number of time units, or divides the pair down by 2 or 4, or inverts it (the last pair only).

The design is digital and needs no analog loop. Every output is a registered compare of the shared counter against the pair's decoded setting. This gives a 50% duty cycle. Configuration changes are held back until the counter wraps, so no pair emits a runt pulse. A hold input together with a test-level input can force pairs into a static level.

Top module: `skew_clk_gen`

## Requirements
- R1: The frequency-select input uses the level encoding 2'b00 = L, 2'b01 = M, 2'b10 = H, and 2'b11 is treated as M. L gives a nominal period of 44 master cycles, M gives 26 and H gives 16.
- R2: Pairs 1 and 2 use a code made of two digits. The first digit is in bits [3:2] and the second in bits [1:0], with the same level encoding as R1. The index is 3*first + second. Indexes 0 to 8 select skews of -4 to +4 time units in steps of one.
- R3: Pair 3 divides the clock by 2 at index 0 (LL) and by 4 at index 8 (HH). Indexes 1 to 7 select skews of -6, -4, -2, 0, +2, +4 and +6 time units.
- R4: Pair 4 uses the same code map as pair 3, except that index 8 (HH) selects the inverted zero-skew clock at the undivided period.
- R5: Every undivided pair is high for N/2 master cycles of each N-cycle period. A pair with skew k rises k cycles after the zero-skew reference, taken modulo N.
- R6: A change on the frequency-select input or on any code takes effect only at the edge where the base counter wraps from N-1 to 0.
- R7: While the test-level input is M and hold is 1, any pair whose code is LL drives 2'b00.
- R8: While pair 4 is in inverted mode and hold is 1, pair 4 drives both bits equal to the polarity input.
- R9: While the synchronous active-low reset is asserted, all outputs are 0 and the counters clear. On the first edge after release, the zero-skew phase starts high.
- R10: Both bits of each output pair always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; one period is one time unit |
| rst_n | input | 1 | Synchronous active-low reset |
| freq_sel | input | 2 | Three-level period select (L/M/H) |
| code_p1 | input | 4 | Pair 1 control code, two three-level digits |
| code_p2 | input | 4 | Pair 2 control code |
| code_p3 | input | 4 | Pair 3 control code |
| code_p4 | input | 4 | Pair 4 control code |
| test_lvl | input | 2 | Three-level test input; M arms the LL disable |
| hold | input | 1 | Output hold request |
| hold_pol | input | 1 | Level driven by pair 4 when it is inverted and held |
| q_p1 | output | 2 | Pair 1 clocks |
| q_p2 | output | 2 | Pair 2 clocks |
| q_p3 | output | 2 | Pair 3 clocks |
| q_p4 | output | 2 | Pair 4 clocks |

## Verification
Each output is registered, so it reflects the counter value at the clock edge that updates it. The zero-skew phase is high in the cycle after the first edge following reset release. A new frequency or code appears in the outputs one edge after the wrap edge that latches it, while hold and the test level act on the next edge. The bench advances its own model of counter, wrap and latching at each rising edge and compares every pair at the following falling edge. It also measures rise offsets, high-phase lengths and periods in cycles counted from reset release.

// File: rtl/skew_pkg.sv
// Shared types and decode helpers for the skew clock generator.
// Assumes three-level signals encoded 00=L, 01=M, 10=H, with 11 folded to M.
package skew_pkg;

    typedef enum logic [1:0] {
        MD_SKEW = 2'd0,
        MD_DIV2 = 2'd1,
        MD_DIV4 = 2'd2,
        MD_INV  = 2'd3
    } pair_mode_e;

    // Fold the illegal level 11 onto M.
    function automatic logic [1:0] lvl(input logic [1:0] d);
        return (d == 2'b11) ? 2'b01 : d;
    endfunction

    // Two-digit code to index 0..8 (first digit weighted by three).
    function automatic logic [3:0] code_idx(input logic [3:0] c);
        return ({2'b00, lvl(c[3:2])} * 4'd3) + {2'b00, lvl(c[1:0])};
    endfunction

endpackage

// File: rtl/skew_timebase.sv
// Base counter modulo N with a two-bit wrap index for divided modes.
// Latches the period selection and all pair codes only at wrap (or in reset),
// so downstream pairs never see a mid-period configuration change.
// Assumes N_LO is the largest period and fits in CW bits.
module skew_timebase
    import skew_pkg::*;
#(
    parameter int N_LO  = 44,
    parameter int N_MID = 26,
    parameter int N_HI  = 16,
    parameter int CW    = 6,
    parameter int PAIRS = 4,
    localparam int CODEW = 4 * PAIRS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       freq_sel,
    input  logic [CODEW-1:0] codes_in,
    output logic [CW-1:0]    cnt,
    output logic [1:0]       per,
    output logic [CW-1:0]    n_act,
    output logic [CODEW-1:0] codes_act
);

    logic [CW-1:0] n_sel;

    // Map the three-level select onto a period length.
    always_comb begin
        case (lvl(freq_sel))
            2'b00:   n_sel = CW'(N_LO);
            2'b10:   n_sel = CW'(N_HI);
            default: n_sel = CW'(N_MID);
        endcase
    end

    // Count master cycles, wrap at N and take new settings only at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            per       <= '0;
            n_act     <= n_sel;
            codes_act <= codes_in;
        end else if (cnt == n_act - CW'(1)) begin
            cnt       <= '0;
            per       <= per + 2'd1;
            n_act     <= n_sel;
            codes_act <= codes_in;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < n_act);

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> (cnt == $past(cnt) + CW'(1)));

    // R6
    settings_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(n_act) || !$stable(codes_act)) |-> (cnt == '0));

endmodule

// File: rtl/skew_pair.sv
// One output pair: decodes its latched code into a mode and skew, compares
// the shared counter against that phase and registers the result onto both bits.
// KIND 0 = fine skew map, 1 = coarse map with /2 and /4, 2 = coarse map with inversion.
// Assumes |skew| stays well below N so one correction step wraps the phase.
module skew_pair
    import skew_pkg::*;
#(
    parameter int KIND = 0,
    parameter int CW   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic [1:0]    per,
    input  logic [CW-1:0] n_act,
    input  logic [3:0]    code,
    input  logic [1:0]    test_lvl,
    input  logic          hold,
    input  logic          hold_pol,
    output logic [1:0]    q
);

    logic [3:0]           idx;
    pair_mode_e           mode;
    logic signed [4:0]    k;
    logic signed [CW+1:0] t;
    logic [CW-1:0]        half;
    logic                 base_hi, zero_hi, val, dis;

    assign idx  = code_idx(code);
    assign half = n_act >> 1;

    if (KIND == 0) begin : g_fine
        // Fine map: one time unit per code step.
        always_comb begin
            mode = MD_SKEW;
            k    = $signed({1'b0, idx}) - 5'sd4;
        end
    end else begin : g_coarse
        // Coarse map: two time units per step, ends pick divide or invert.
        always_comb begin
            k = '0;
            if (idx == 4'd0) begin
                mode = MD_DIV2;
            end else if (idx == 4'd8) begin
                mode = (KIND == 2) ? MD_INV : MD_DIV4;
            end else begin
                mode = MD_SKEW;
                k    = ($signed({1'b0, idx}) - 5'sd4) <<< 1;
            end
        end
    end

    // Phase of this pair: (cnt - k) folded back into 0..N-1.
    always_comb begin
        t = $signed({2'b00, cnt}) - $signed({{(CW-3){k[4]}}, k});
        if (t < 0)
            t = t + $signed({2'b00, n_act});
        else if (t >= $signed({2'b00, n_act}))
            t = t - $signed({2'b00, n_act});
        base_hi = (t[CW-1:0] < half);
        zero_hi = (cnt < half);
    end

    // Select the waveform by mode, then apply disable and hold overrides.
    always_comb begin
        case (mode)
            MD_DIV2: val = ~per[0];
            MD_DIV4: val = ~per[1];
            MD_INV:  val = ~zero_hi;
            default: val = base_hi;
        endcase
        dis = (lvl(test_lvl) == 2'b01) && hold && (idx == 4'd0);
        if (dis)
            val = 1'b0;
        else if ((mode == MD_INV) && hold)
            val = hold_pol;
    end

    // Register the pair so every edge is clean and aligned to the master clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 2'b00;
        else
            q <= {2{val}};
    end

    // R9
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (q == 2'b00));

    // R7
    dis_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((test_lvl == 2'b01 || test_lvl == 2'b11) && hold && code == 4'b0000) |=> (q == 2'b00));

endmodule

// File: rtl/skew_clk_gen.sv
// Top of the programmable skew clock generator: one shared timebase and
// four output pairs built in a generate loop (two fine, one divider, one invert).
// Assumes N_LO >= N_MID >= N_HI and all periods even.
module skew_clk_gen
    import skew_pkg::*;
#(
    parameter int N_LO  = 44,
    parameter int N_MID = 26,
    parameter int N_HI  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] freq_sel,
    input  logic [3:0] code_p1,
    input  logic [3:0] code_p2,
    input  logic [3:0] code_p3,
    input  logic [3:0] code_p4,
    input  logic [1:0] test_lvl,
    input  logic       hold,
    input  logic       hold_pol,
    output logic [1:0] q_p1,
    output logic [1:0] q_p2,
    output logic [1:0] q_p3,
    output logic [1:0] q_p4
);

    localparam int PAIRS = 4;
    localparam int CW    = $clog2(N_LO + 1);

    logic [CW-1:0]      cnt, n_act;
    logic [1:0]         per;
    logic [4*PAIRS-1:0] codes_act;
    logic [1:0]         q_arr [PAIRS];

    skew_timebase #(
        .N_LO(N_LO), .N_MID(N_MID), .N_HI(N_HI), .CW(CW), .PAIRS(PAIRS)
    ) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .freq_sel  (freq_sel),
        .codes_in  ({code_p4, code_p3, code_p2, code_p1}),
        .cnt       (cnt),
        .per       (per),
        .n_act     (n_act),
        .codes_act (codes_act)
    );

    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        localparam int KIND = (i < 2) ? 0 : ((i == 2) ? 1 : 2);
        skew_pair #(.KIND(KIND), .CW(CW)) u_pair (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt),
            .per      (per),
            .n_act    (n_act),
            .code     (codes_act[4*i +: 4]),
            .test_lvl (test_lvl),
            .hold     (hold),
            .hold_pol (hold_pol),
            .q        (q_arr[i])
        );
    end

    assign q_p1 = q_arr[0];
    assign q_p2 = q_arr[1];
    assign q_p3 = q_arr[2];
    assign q_p4 = q_arr[3];

endmodule

// File: tb/skew_clk_gen_test.sv
// Self-checking bench: cycle model of counter, wrap and latching built from
// the requirements, directed corner cases plus seeded random configurations.
module skew_clk_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] freq_sel = 2'b01;
    logic [3:0] code [4];
    logic [1:0] test_lvl = 2'b00;
    logic       hold = 1'b0;
    logic       hold_pol = 1'b0;
    logic [1:0] q_p1, q_p2, q_p3, q_p4;

    always #10 clk = ~clk;

    skew_clk_gen uut (
        .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel),
        .code_p1(code[0]), .code_p2(code[1]), .code_p3(code[2]), .code_p4(code[3]),
        .test_lvl(test_lvl), .hold(hold), .hold_pol(hold_pol),
        .q_p1(q_p1), .q_p2(q_p2), .q_p3(q_p3), .q_p4(q_p4)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int wd = 0;

    // model state
    int         m_c, m_per, m_n, cyc, rise_from;
    logic [3:0] m_code [4];
    logic       m_q [4];
    logic       prev [4];
    int         seg_err [4];
    int         hi_cnt [4];
    int         rise [4];
    logic       ref_smp [256];

    int fine_k [9]   = '{-4, -3, -2, -1, 0, 1, 2, 3, 4};
    int coarse_k [9] = '{0, -6, -4, -2, 0, 2, 4, 6, 0};

    function automatic int lv(logic [1:0] d);
        return (d == 2'b11) ? 1 : int'(d);
    endfunction

    function automatic int nsel(logic [1:0] f);
        return (lv(f) == 0) ? 44 : ((lv(f) == 2) ? 16 : 26);
    endfunction

    function automatic logic ev(int kind, logic [3:0] cd, int c, int pr, int n,
                                logic [1:0] tst, logic hd, logic pl);
        int idx, k, t;
        logic v;
        bit inv;
        inv = 0;
        k = 0;
        idx = 3 * lv(cd[3:2]) + lv(cd[1:0]);
        if (kind == 0) begin
            k = fine_k[idx];
            t = ((c - k) % n + n) % n;
            v = (t < n / 2);
        end else if (idx == 0) begin
            v = ((pr % 2) == 0);
        end else if (idx == 8 && kind == 1) begin
            v = ((pr % 4) < 2);
        end else if (idx == 8) begin
            inv = 1;
            v = !(c < n / 2);
        end else begin
            k = coarse_k[idx];
            t = ((c - k) % n + n) % n;
            v = (t < n / 2);
        end
        if (lv(tst) == 1 && hd && idx == 0) v = 1'b0;
        else if (inv && hd) v = pl;
        return v;
    endfunction

    function automatic logic [1:0] q_of(int p);
        case (p)
            0: return q_p1;
            1: return q_p2;
            2: return q_p3;
            default: return q_p4;
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Advance the model at the rising edge, compare at the falling edge.
    task automatic tick();
        int idx_now;
        @(posedge clk);
        idx_now = -1;
        if (!rst_n) begin
            m_c = 0; m_per = 0; m_n = nsel(freq_sel);
            for (int p = 0; p < 4; p++) begin m_code[p] = code[p]; m_q[p] = 1'b0; end
        end else begin
            for (int p = 0; p < 4; p++)
                m_q[p] = ev((p < 2) ? 0 : ((p == 2) ? 1 : 2), m_code[p], m_c, m_per, m_n,
                            test_lvl, hold, hold_pol);
            if (m_c == m_n - 1) begin
                m_c = 0; m_per = (m_per + 1) % 4; m_n = nsel(freq_sel);
                for (int p = 0; p < 4; p++) m_code[p] = code[p];
            end else begin
                m_c++;
            end
            idx_now = cyc;
            cyc++;
        end
        @(negedge clk);
        for (int p = 0; p < 4; p++) begin
            logic [1:0] g;
            g = q_of(p);
            if (g !== {2{m_q[p]}}) seg_err[p]++;
            if (g[0] === 1'b1) hi_cnt[p]++;
            if (idx_now >= rise_from && prev[p] === 1'b0 && g[0] === 1'b1 && rise[p] < 0)
                rise[p] = idx_now;
            prev[p] = g[0];
        end
        if (idx_now >= 0 && idx_now < 256) ref_smp[idx_now] = q_p2[0];
    endtask

    task automatic clear_seg(int rf);
        rise_from = rf;
        for (int p = 0; p < 4; p++) begin seg_err[p] = 0; hi_cnt[p] = 0; rise[p] = -1; end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        cyc = 0;
        rst_n = 1'b1;
    endtask

    task automatic seg_check(string req);
        for (int p = 0; p < 4; p++)
            check(seg_err[p] == 0, req, seg_err[p], 0);
    endtask

    task automatic cfg(logic [1:0] f, logic [3:0] c1, logic [3:0] c2, logic [3:0] c3,
                       logic [3:0] c4, logic [1:0] tl, logic hd, logic pl);
        freq_sel = f; code[0] = c1; code[1] = c2; code[2] = c3; code[3] = c4;
        test_lvl = tl; hold = hd; hold_pol = pl;
    endtask

    // watchdog: counts as a failed check and still prints the summary
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected 0", wd);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        for (int p = 0; p < 4; p++) begin code[p] = 4'b0101; prev[p] = 1'b0; end
        cyc = 0;
        clear_seg(1);

        // R9: outputs low while reset is held
        repeat (4) tick();
        for (int p = 0; p < 4; p++)
            check(q_of(p) == 2'b00, "R9 reset low", int'(q_of(p)), 0);

        // R1 R5 R9: zero-skew period and duty for each select level, 11 as M
        for (int f = 0; f < 4; f++) begin
            int n, hc;
            cfg(2'(f), 4'b0101, 4'b0101, 4'b0101, 4'b0101, 2'b00, 1'b0, 1'b0);
            n = nsel(2'(f));
            do_reset();
            clear_seg(1);
            repeat (2 * n + 2) tick();
            hc = 0;
            for (int i = 0; i < n; i++) if (ref_smp[i] === 1'b1) hc++;
            check(ref_smp[0] === 1'b1, "R9 first edge high", int'(ref_smp[0]), 1);
            check(hc == n / 2, "R5 high phase", hc, n / 2);
            check(rise[1] == n, "R1 period", rise[1], n);
            seg_check("R1");
        end

        // R2 R3 R4 R10: every code on every pair at every select level
        for (int f = 0; f < 3; f++) begin
            for (int a = 0; a < 3; a++) begin
                for (int b = 0; b < 3; b++) begin
                    logic [3:0] cc;
                    cc = {2'(a), 2'(b)};
                    cfg(2'(f), cc, cc, cc, cc, 2'b00, 1'b0, 1'b0);
                    do_reset();
                    clear_seg(1);
                    repeat (4 * nsel(2'(f)) + 4) tick();
                    check(seg_err[0] == 0 && seg_err[1] == 0, "R2 fine map R10", seg_err[0] + seg_err[1], 0);
                    check(seg_err[2] == 0, "R3 coarse map", seg_err[2], 0);
                    check(seg_err[3] == 0, "R4 invert map", seg_err[3], 0);
                end
            end
        end

        // R2 R3 R4 R5: rise offsets after the first period, N = 26
        cfg(2'b01, 4'b0000, 4'b1010, 4'b0110, 4'b1001, 2'b00, 1'b0, 1'b0);
        do_reset(); clear_seg(26);
        repeat (80) tick();
        check(rise[0] == 48, "R2 skew -4", rise[0], 48);
        check(rise[1] == 30, "R2 skew +4", rise[1], 30);
        check(rise[2] == 28, "R3 skew +2", rise[2], 28);
        check(rise[3] == 32, "R4 skew +6", rise[3], 32);

        cfg(2'b01, 4'b0101, 4'b0100, 4'b0001, 4'b0100, 2'b00, 1'b0, 1'b0);
        do_reset(); clear_seg(26);
        repeat (80) tick();
        check(rise[0] == 26, "R2 zero skew", rise[0], 26);
        check(rise[1] == 51, "R2 skew -1", rise[1], 51);
        check(rise[2] == 46, "R3 skew -6", rise[2], 46);
        check(rise[3] == 50, "R4 skew -2", rise[3], 50);

        cfg(2'b01, 4'b0101, 4'b0101, 4'b1010, 4'b1010, 2'b00, 1'b0, 1'b0);
        do_reset(); clear_seg(26);
        repeat (110) tick();
        check(rise[2] == 104, "R3 divide by 4", rise[2], 104);
        check(rise[3] == 39, "R4 inverted", rise[3], 39);
        cfg(2'b01, 4'b0101, 4'b0101, 4'b0000, 4'b0000, 2'b00, 1'b0, 1'b0);
        do_reset(); clear_seg(26);
        repeat (60) tick();
        check(rise[2] == 52, "R3 divide by 2", rise[2], 52);
        check(rise[3] == 52, "R4 divide by 2", rise[3], 52);

        // R7: LL disabled under test M with hold; not under test L
        cfg(2'b10, 4'b0000, 4'b0101, 4'b0000, 4'b0000, 2'b01, 1'b1, 1'b0);
        do_reset(); clear_seg(1);
        repeat (70) tick();
        check(hi_cnt[0] == 0 && hi_cnt[2] == 0 && hi_cnt[3] == 0, "R7 disabled LL",
              hi_cnt[0] + hi_cnt[2] + hi_cnt[3], 0);
        check(hi_cnt[1] > 0, "R7 non-LL runs", hi_cnt[1], 35);
        seg_check("R7");
        cfg(2'b10, 4'b0000, 4'b0101, 4'b0000, 4'b0000, 2'b00, 1'b1, 1'b0);
        clear_seg(1);
        repeat (40) tick();
        check(hi_cnt[0] > 0, "R7 test L keeps running", hi_cnt[0], 20);
        seg_check("R7");

        // R8: inverted pair 4 held to the polarity level
        cfg(2'b00, 4'b0101, 4'b0101, 4'b0101, 4'b1010, 2'b00, 1'b1, 1'b1);
        do_reset(); clear_seg(1);
        repeat (60) tick();
        check(hi_cnt[3] == 60, "R8 hold high", hi_cnt[3], 60);
        hold_pol = 1'b0;
        tick();
        clear_seg(1);
        repeat (60) tick();
        check(hi_cnt[3] == 0, "R8 hold low", hi_cnt[3], 0);
        seg_check("R8");

        // R6: select and code change mid-period wait for the wrap
        cfg(2'b01, 4'b0101, 4'b0101, 4'b0101, 4'b0101, 2'b00, 1'b0, 1'b0);
        do_reset(); clear_seg(1);
        repeat (10) tick();
        freq_sel = 2'b00; code[0] = 4'b1010;
        repeat (120) tick();
        check(rise[1] == 26, "R6 old period kept", rise[1], 26);
        seg_check("R6");

        // R1..R8 random configurations, some changed without reset
        for (int r = 0; r < 40; r++) begin
            cfg(2'($urandom), 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
                2'($urandom), 1'($urandom), 1'($urandom));
            if (r % 3 != 0) do_reset();
            clear_seg(1);
            repeat (4 * nsel(freq_sel) + 50) tick();
            seg_check("R6 random R10");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule